// File: doc/BRIEF.md
# Nonvolatile Store Cycle Sequencer

This block times the commit of data-register updates inside a multi-channel digital potentiometer controller. A command decoder hands it at most one store request per serial frame: a direct register write, a copy of one channel's wiper position into one of its registers, or a copy of every channel's wiper position into the same register slot of each channel. The request is held while the frame stays open, and the timed store begins only when chip select is released.

During the store a write-in-progress flag stays high for a fixed number of clock cycles, and the decoder can return it to a status read. When the count runs out, the register bank takes the new values in one clock edge. A write-protect input and a busy store both drop new requests. Two power-up lockouts, one for reads and one for writes, are counted out after reset. The decoder uses them to gate the commands it accepts. All times are clock-count parameters.

Top module: `nv_store_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it, `wip`, `read_ok` and `write_ok` are 0 and every register slot holds 0.
- R2: After reset release, `read_ok` is 0 until READ_LOCK rising edges have passed and is 1 from then on. `write_ok` behaves the same way with WRITE_LOCK. `read_ok` is never lower than `write_ok`.
- R3: A request presented while `write_ok` is 0 is dropped and causes no store.
- R4: A request presented while `wr_protect_n` is 0 is dropped: no store follows and the bank is unchanged.
- R5: A request is taken only while `cs_n` is 0. A store starts only when `cs_n` is sampled 0 and then 1 with a request held. `wip` reads 1 in the cycle after the clock edge that sees `cs_n` high. Nothing changes while the frame is open, and a release of `cs_n` with no request held starts nothing.
- R6: `wip` stays 1 for exactly STORE_CYCLES cycles. The bank changes only on the clock edge at which `wip` falls.
- R7: Kind code 1 (write) loads `req_data` into register `req_reg` of channel `req_chan`.
- R8: Kind code 2 (copy) loads register `req_reg` of channel `req_chan` with that channel's slice of `wiper_in` as it was when the request was taken. Later changes to `wiper_in` have no effect.
- R9: Kind code 3 (global copy) loads register `req_reg` of every channel with its own `wiper_in` slice, taken when the request was taken, all within one store.
- R10: A request presented while `wip` is 1 is dropped.
- R11: Kind code 0 is not a request and causes no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| wr_protect_n | input | 1 | Active-low write protect |
| req_valid | input | 1 | One-cycle request strobe from the decoder |
| req_kind | input | 2 | 0 none, 1 write, 2 copy, 3 global copy |
| req_chan | input | CHW | Target channel |
| req_reg | input | RGW | Target register slot |
| req_data | input | DW | Data for a write |
| wiper_in | input | NCH*DW | Current wiper positions; channel c at bits c*DW upward |
| wip | output | 1 | Store in progress |
| read_ok | output | 1 | Read lockout has expired |
| write_ok | output | 1 | Write lockout has expired |
| bank_q | output | NCH*NREG*DW | Register bank; slot (c,r) at bit ((c*NREG)+r)*DW upward |

## Verification
The assertions assume that `cs_n` is synchronous to the clock and stays high through reset. They also assume that `req_valid` lasts one cycle with its fields stable during that cycle. The bench changes every input on the falling clock edge and holds `cs_n` high during reset. It issues each request inside an open frame, and it changes `wiper_in` after a copy request to show which value was captured. To test the drop rule while busy, a second frame is opened deliberately during a store.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
   typedef enum logic [1:0] {
      K_NONE   = 2'd0,
      K_WRITE  = 2'd1,
      K_COPY   = 2'd2,
      K_GLOBAL = 2'd3
   } store_kind_e;
endpackage

// File: rtl/nvseq_powerup.sv
module nvseq_powerup #(
   parameter int READ_LOCK  = 50000,
   parameter int WRITE_LOCK = 250000
) (
   input  logic clk,
   input  logic rst_n,
   output logic read_ok,
   output logic write_ok
);
   localparam int CW = $clog2(WRITE_LOCK + 1);

   if (READ_LOCK < 1 || READ_LOCK > WRITE_LOCK) begin : g_bad_lock
      $error("nvseq_powerup: need 1 <= READ_LOCK <= WRITE_LOCK");
   end

   logic [CW-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age_q <= '0;
      else if (age_q != CW'(WRITE_LOCK))
         age_q <= age_q + 1'b1;
   end

   assign read_ok  = (age_q >= CW'(READ_LOCK));
   assign write_ok = (age_q == CW'(WRITE_LOCK));

   // R2: once open, the read gate never closes again
   p_read_sticky_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      read_ok |=> read_ok);
   p_write_sticky_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      write_ok |=> write_ok);
endmodule

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
   parameter int STORE_CYCLES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = (STORE_CYCLES > 2) ? $clog2(STORE_CYCLES) : 1;

   if (STORE_CYCLES < 2) begin : g_bad_len
      $error("nvseq_timer: STORE_CYCLES must be at least 2");
   end

   logic [CW-1:0] left_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         left_q <= CW'(STORE_CYCLES - 1);
      end else if (busy_q) begin
         if (left_q == '0)
            busy_q <= 1'b0;
         else
            left_q <= left_q - 1'b1;
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (left_q == '0);

   // R6: the busy window cannot end before its count is spent
   p_busy_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && left_q != '0) |=> busy_q);
   p_done_ends_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy_q);
endmodule

// File: rtl/nvseq_bank.sv
module nvseq_bank
   import nvseq_pkg::*;
#(
   parameter int             NCH   = 4,
   parameter int             NREG  = 4,
   parameter int             DW    = 6,
   parameter logic [DW-1:0]  INIT  = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   commit,
   input  store_kind_e            kind,
   input  logic [$clog2(NCH)-1:0] chan,
   input  logic [$clog2(NREG)-1:0] reg_sel,
   input  logic [NCH*DW-1:0]      vals,
   output logic [NCH*NREG*DW-1:0] bank_q
);
   localparam int CHW = $clog2(NCH);
   localparam int RGW = $clog2(NREG);

   if (NCH < 2 || NREG < 2 || DW < 1) begin : g_bad_shape
      $error("nvseq_bank: need NCH >= 2, NREG >= 2, DW >= 1");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit_ch;
      assign hit_ch = (kind == K_GLOBAL) || (chan == CHW'(c));
      for (genvar r = 0; r < NREG; r++) begin : g_rg
         logic [DW-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q <= INIT;
            else if (commit && hit_ch && reg_sel == RGW'(r))
               slot_q <= vals[c*DW +: DW];
         end
         assign bank_q[((c*NREG)+r)*DW +: DW] = slot_q;
      end
   end

   // R6: without a commit strobe the bank holds
   p_quiet_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(bank_q));
endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq
   import nvseq_pkg::*;
#(
   parameter int NCH          = 4,
   parameter int NREG         = 4,
   parameter int DW           = 6,
   parameter int STORE_CYCLES = 500000,
   parameter int READ_LOCK    = 50000,
   parameter int WRITE_LOCK   = 250000,
   localparam int CHW = $clog2(NCH),
   localparam int RGW = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   wr_protect_n,
   input  logic                   req_valid,
   input  logic [1:0]             req_kind,
   input  logic [CHW-1:0]         req_chan,
   input  logic [RGW-1:0]         req_reg,
   input  logic [DW-1:0]          req_data,
   input  logic [NCH*DW-1:0]      wiper_in,
   output logic                   wip,
   output logic                   read_ok,
   output logic                   write_ok,
   output logic [NCH*NREG*DW-1:0] bank_q
);
   store_kind_e      kind_in;
   logic             cs_q;
   logic             cs_rise;
   logic             accept;
   logic             start;
   logic             done;
   logic             pend_q;
   store_kind_e      p_kind_q;
   logic [CHW-1:0]   p_chan_q;
   logic [RGW-1:0]   p_reg_q;
   logic [NCH*DW-1:0] p_vals_q;
   logic [NCH*DW-1:0] vals_nx;

   assign kind_in = store_kind_e'(req_kind);

   nvseq_powerup #(.READ_LOCK(READ_LOCK), .WRITE_LOCK(WRITE_LOCK)) u_pwr (
      .clk(clk), .rst_n(rst_n), .read_ok(read_ok), .write_ok(write_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_q <= 1'b1;
      else        cs_q <= cs_n;
   end
   assign cs_rise = cs_n && !cs_q;

   assign accept = req_valid && !cs_n && write_ok && !wip &&
                   wr_protect_n && (kind_in != K_NONE);

   always_comb begin
      vals_nx = wiper_in;
      if (kind_in == K_WRITE) begin
         for (int c = 0; c < NCH; c++)
            if (req_chan == CHW'(c)) vals_nx[c*DW +: DW] = req_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         p_kind_q <= K_NONE;
         p_chan_q <= '0;
         p_reg_q  <= '0;
         p_vals_q <= '0;
      end else if (start) begin
         pend_q   <= 1'b0;
      end else if (accept) begin
         pend_q   <= 1'b1;
         p_kind_q <= kind_in;
         p_chan_q <= req_chan;
         p_reg_q  <= req_reg;
         p_vals_q <= vals_nx;
      end
   end

   assign start = cs_rise && pend_q;

   nvseq_timer #(.STORE_CYCLES(STORE_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(wip), .done(done));

   nvseq_bank #(.NCH(NCH), .NREG(NREG), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n), .commit(done), .kind(p_kind_q),
      .chan(p_chan_q), .reg_sel(p_reg_q), .vals(p_vals_q), .bank_q(bank_q));

   // R5: a store begins only right after chip select is released
   p_start_on_rise_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> ($past(cs_n) && !$past(cs_n, 2)));
   // R3: no store while writes are locked out
   p_lock_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !write_ok |-> !wip);
   // R2: the read gate opens no later than the write gate
   p_order_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      write_ok |-> read_ok);
   // R4: protect held low keeps the request slot empty
   p_protect_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_protect_n && !pend_q) |=> !pend_q);
   // R10: nothing is queued while a store runs
   p_busy_drop_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      wip |-> !pend_q);
endmodule

// File: tb/tb_nv_store_seq.sv
module tb_nv_store_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4, NREG = 4, DW = 6;
   localparam int STORE = 40, RL = 20, WL = 50;
   localparam int BW = NCH*NREG*DW;

   logic clk = 0, rst_n = 0, cs_n = 1, wr_protect_n = 1, req_valid = 0;
   logic [1:0] req_kind = 0, req_chan = 0, req_reg = 0;
   logic [DW-1:0] req_data = 0;
   logic [NCH*DW-1:0] wiper_in = 24'h0;
   logic wip, read_ok, write_ok;
   logic [BW-1:0] bank_q;

   nv_store_seq #(.NCH(NCH), .NREG(NREG), .DW(DW), .STORE_CYCLES(STORE),
                  .READ_LOCK(RL), .WRITE_LOCK(WL)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_protect_n(wr_protect_n),
      .req_valid(req_valid), .req_kind(req_kind), .req_chan(req_chan),
      .req_reg(req_reg), .req_data(req_data), .wiper_in(wiper_in),
      .wip(wip), .read_ok(read_ok), .write_ok(write_ok), .bank_q(bank_q));

   always #(CLK_PERIOD/2) clk = ~clk;

   int nchk = 0, nfail = 0, cyc = 0;
   logic [DW-1:0] model [NCH][NREG];
   logic [BW-1:0] expq [$];
   string tagq [$];
   logic prev_wip = 0;

   always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

   function automatic logic [BW-1:0] pack();
      logic [BW-1:0] v;
      for (int c = 0; c < NCH; c++)
         for (int r = 0; r < NREG; r++)
            v[((c*NREG)+r)*DW +: DW] = model[c][r];
      return v;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   // monitor: at every end of a store, compare against the next expected image
   always @(negedge clk) begin
      if (rst_n && prev_wip && !wip) begin
         if (expq.size() == 0)
            chk(0, "R6 unexpected commit", bank_q, '0);
         else begin
            logic [BW-1:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            chk(bank_q == e, t, bank_q, e);
         end
      end
      prev_wip = wip;
   end

   task automatic apply(input logic [1:0] kind, input int ch, input int rg,
                        input logic [DW-1:0] d, input logic [NCH*DW-1:0] ws);
      if (kind == 2'd1) model[ch][rg] = d;
      else if (kind == 2'd2) model[ch][rg] = ws[ch*DW +: DW];
      else if (kind == 2'd3)
         for (int c = 0; c < NCH; c++) model[c][rg] = ws[c*DW +: DW];
   endtask

   task automatic frame(input logic [1:0] kind, input int ch, input int rg,
                        input logic [DW-1:0] d, input bit wp, input bit exp_st,
                        input string tag);
      logic [NCH*DW-1:0] ws;
      int n;
      @(negedge clk); cs_n = 0; wr_protect_n = wp;
      @(negedge clk); req_valid = 1; req_kind = kind; req_chan = 2'(ch);
      req_reg = 2'(rg); req_data = d; ws = wiper_in;
      @(negedge clk); req_valid = 0; wiper_in = ~wiper_in;
      @(negedge clk);
      chk(wip == 0 && bank_q == pack(), "R5 frame open", {95'b0, wip}, pack());
      cs_n = 1;
      if (exp_st) begin
         apply(kind, ch, rg, d, ws);
         expq.push_back(pack());
         tagq.push_back(tag);
      end
      @(negedge clk);
      chk(wip == exp_st, {tag, " R5 wip start"}, BW'(wip), BW'(exp_st));
      if (exp_st) begin
         n = 0;
         while (wip === 1'b1 && n < STORE + 10) begin n++; @(negedge clk); end
         chk(n == STORE, "R6 wip length", BW'(n), BW'(STORE));
      end else begin
         repeat (3) @(negedge clk);
         chk(wip == 0 && bank_q == pack(), tag, bank_q, pack());
      end
      wr_protect_n = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      for (int c = 0; c < NCH; c++) for (int r = 0; r < NREG; r++) model[c][r] = '0;
      wiper_in = {6'd7, 6'd19, 6'd33, 6'd50};
      repeat (3) @(negedge clk);
      chk(wip == 0 && read_ok == 0 && write_ok == 0 && bank_q == '0, "R1 reset",
          {bank_q, wip, read_ok, write_ok}, '0);
      rst_n = 1;
      @(negedge clk);
      chk(wip == 0 && read_ok == 0 && write_ok == 0 && bank_q == '0, "R1 after release",
          {bank_q, wip, read_ok, write_ok}, '0);
      while (cyc < RL - 1) @(negedge clk);
      chk(read_ok == 0, "R2 read lock held", BW'(read_ok), 0);
      @(negedge clk);
      chk(read_ok == 1 && write_ok == 0, "R2 read lock ends", {read_ok, write_ok}, 2'b10);
      // R3: write attempt while still locked
      frame(2'd1, 0, 0, 6'h05, 1'b1, 1'b0, "R3 locked request dropped");
      while (cyc < WL - 1) @(negedge clk);
      chk(write_ok == 0, "R2 write lock held", BW'(write_ok), 0);
      @(negedge clk);
      chk(write_ok == 1 && read_ok == 1, "R2 write lock ends", {read_ok, write_ok}, 2'b11);

      frame(2'd1, 2, 1, 6'h2A, 1'b1, 1'b1, "R7 write");
      frame(2'd1, 0, 3, 6'h3F, 1'b1, 1'b1, "R7 write max");
      frame(2'd2, 1, 3, 6'h00, 1'b1, 1'b1, "R8 copy captured");
      frame(2'd3, 0, 2, 6'h00, 1'b1, 1'b1, "R9 global copy");
      frame(2'd1, 3, 0, 6'h15, 1'b0, 1'b0, "R4 protect write");
      frame(2'd3, 0, 1, 6'h00, 1'b0, 1'b0, "R4 protect global");
      frame(2'd0, 1, 1, 6'h2B, 1'b1, 1'b0, "R11 kind none");

      // R5: release with nothing held
      @(negedge clk); cs_n = 0;
      repeat (2) @(negedge clk); cs_n = 1;
      repeat (3) @(negedge clk);
      chk(wip == 0 && bank_q == pack(), "R5 empty frame", bank_q, pack());

      // R10: request inside a frame opened during a store
      @(negedge clk); cs_n = 0;
      @(negedge clk); req_valid = 1; req_kind = 2'd1; req_chan = 2'd3; req_reg = 2'd0; req_data = 6'h11;
      @(negedge clk); req_valid = 0;
      @(negedge clk); cs_n = 1;
      model[3][0] = 6'h11; expq.push_back(pack()); tagq.push_back("R10 first store");
      @(negedge clk);
      chk(wip == 1, "R10 store running", BW'(wip), 1);
      cs_n = 0;
      @(negedge clk); req_valid = 1; req_data = 6'h3E;
      @(negedge clk); req_valid = 0;
      @(negedge clk); cs_n = 1;
      while (wip) @(negedge clk);
      begin
         bit seen = 0;
         repeat (STORE + 5) begin @(negedge clk); if (wip) seen = 1; end
         chk(!seen && bank_q == pack(), "R10 busy request dropped", bank_q, pack());
      end
      chk(expq.size() == 0, "R6 all stores committed", BW'(expq.size()), 0);
      report();
   end
endmodule